// File: doc/BRIEF.md
# Programmed-I/O Drive Strobe Timing Generator

This block shapes the read or write strobe for a single programmed-I/O access to a disk drive on a two-drive cable. A one-clock start request launches the access. The block picks one of four 8-bit timing words using two inputs. The first is which drive is addressed (drive 0 or drive 1). The second is whether the access targets the data register or one of the other task-file registers. The chosen word and the transfer direction are captured at the start. The block then drives one strobe for a programmed active span, holds both strobes low for a programmed recovery span, and reports completion with a one-clock done pulse.

Each timing word holds two biased 4-bit fields. The recovery field sits in bits 7:4 and the active field in bits 3:0. Each field gives its span in bus clocks minus one, so both spans run from 1 to 16 clocks. Address decode and data capture are handled elsewhere. The surrounding logic only supplies the four words, issues a start, and waits for done.

Top module: `pio_strobe_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it is released with no start, both strobes, busy and done are low.
- R2: The active span lasts (bits 3:0 of the selected word) + 1 clocks, from 1 clock for value 0 to 16 clocks for value 15.
- R3: The recovery span, in which busy is high while both strobes and done are low, lasts (bits 7:4 of the selected word) + 1 clocks, from 1 to 16.
- R4: The word used is chosen as follows. With the drive select at 0 and the class flag at 1 (data register) it is the drive 0 data word. With drive 0 and class 0 it is the drive 0 register word. With drive 1 the same rule picks the drive 1 data word or the drive 1 register word.
- R5: The word and direction are captured in the cycle in which the start is accepted. Changing the timing inputs during an access does not change its spans.
- R6: Only one strobe is driven, and only during the active span. A direction flag of 1 selects the read strobe and 0 selects the write strobe. Both strobes are low in recovery, in the done cycle and when idle.
- R7: After the recovery span, done is high for exactly one clock. The next cycle the block is idle.
- R8: Busy rises in the clock after the start is accepted and stays high through the done cycle. It is high for active + recovery + 1 clocks in total, and the strobe is already asserted in that first busy clock.
- R9: A start that arrives while busy is ignored. It produces no additional access and leaves the current access unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-clock access request |
| drive_i | input | 1 | Drive select, 0 = drive 0, 1 = drive 1 |
| data_cls_i | input | 1 | 1 = data register access, 0 = other task-file register |
| rd_nwr_i | input | 1 | 1 = read, 0 = write |
| tw_d0_data_i | input | 8 | Drive 0 data timing word (rec[7:4], act[3:0]) |
| tw_d0_reg_i | input | 8 | Drive 0 register timing word |
| tw_d1_data_i | input | 8 | Drive 1 data timing word |
| tw_d1_reg_i | input | 8 | Drive 1 register timing word |
| rd_strobe_o | output | 1 | Read strobe, high during the active span of a read |
| wr_strobe_o | output | 1 | Write strobe, high during the active span of a write |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The bound checker watches several properties on every clock. It checks that the two strobes never overlap, that a strobe never appears outside busy or together with done, and that done is a single pulse followed by idle. It also checks that an accepted start always raises busy, that busy persists until done, that every strobe is followed by at least one recovery clock, and that neither span exceeds 16 clocks. Only the bench scenarios can show that the spans equal the exact programmed values and that the right word is used for each drive and class. The same holds for latching at start under changing words, for the 1-clock and 16-clock extremes, and for a start during an access producing no second access.

// File: rtl/pio_strobe_pkg.sv
package pio_strobe_pkg;

    localparam int NIB_W   = 4;
    localparam int WORD_W  = 2 * NIB_W;
    localparam int N_SETS  = 4;
    localparam int SEL_W   = $clog2(N_SETS);
    localparam int SPAN_MAX = 1 << NIB_W;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ACTIVE  = 2'd1,
        PH_RECOVER = 2'd2,
        PH_DONE    = 2'd3
    } phase_e;

    typedef struct packed {
        logic [NIB_W-1:0] rec;
        logic [NIB_W-1:0] act;
    } tword_t;

    typedef struct packed {
        logic   is_read;
        tword_t tw;
    } access_t;

    // Set order: 0 drive0 data, 1 drive0 reg, 2 drive1 data, 3 drive1 reg
    function automatic logic [SEL_W-1:0] set_index(input logic drive, input logic data_cls);
        return {drive, ~data_cls};
    endfunction

endpackage

// File: rtl/pio_timing_mux.sv
module pio_timing_mux
    import pio_strobe_pkg::*;
(
    input  tword_t           tw_set [N_SETS],
    input  logic [SEL_W-1:0] sel,
    output tword_t           tw_sel
);

    always_comb begin
        tw_sel = tw_set[0];
        for (int i = 1; i < N_SETS; i++) begin
            if (sel == SEL_W'(i)) begin
                tw_sel = tw_set[i];
            end
        end
    end

endmodule

// File: rtl/pio_phase_cnt.sv
module pio_phase_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
    import pio_strobe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              drive_i,
    input  logic              data_cls_i,
    input  logic              rd_nwr_i,
    input  logic [WORD_W-1:0] tw_d0_data_i,
    input  logic [WORD_W-1:0] tw_d0_reg_i,
    input  logic [WORD_W-1:0] tw_d1_data_i,
    input  logic [WORD_W-1:0] tw_d1_reg_i,
    output logic              rd_strobe_o,
    output logic              wr_strobe_o,
    output logic              busy_o,
    output logic              done_o
);

    tword_t  tw_set [N_SETS];
    tword_t  tw_sel;
    access_t acc_q;
    phase_e  phase_q, phase_d;
    logic    accept;
    logic    cnt_load, cnt_dec, cnt_zero;
    logic [NIB_W-1:0] cnt_val;

    assign tw_set[0] = tword_t'(tw_d0_data_i);
    assign tw_set[1] = tword_t'(tw_d0_reg_i);
    assign tw_set[2] = tword_t'(tw_d1_data_i);
    assign tw_set[3] = tword_t'(tw_d1_reg_i);

    pio_timing_mux i_mux (
        .tw_set (tw_set),
        .sel    (set_index(drive_i, data_cls_i)),
        .tw_sel (tw_sel)
    );

    assign accept = (phase_q == PH_IDLE) && start_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (accept) begin
            acc_q.is_read <= rd_nwr_i;
            acc_q.tw      <= tw_sel;
        end
    end

    assign cnt_load = accept || ((phase_q == PH_ACTIVE) && cnt_zero);
    assign cnt_val  = (phase_q == PH_IDLE) ? tw_sel.act : acc_q.tw.rec;
    assign cnt_dec  = (phase_q == PH_ACTIVE) || (phase_q == PH_RECOVER);

    pio_phase_cnt #(.W(NIB_W)) i_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:    if (start_i)  phase_d = PH_ACTIVE;
            PH_ACTIVE:  if (cnt_zero) phase_d = PH_RECOVER;
            PH_RECOVER: if (cnt_zero) phase_d = PH_DONE;
            PH_DONE:                  phase_d = PH_IDLE;
            default:                  phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign rd_strobe_o = (phase_q == PH_ACTIVE) &&  acc_q.is_read;
    assign wr_strobe_o = (phase_q == PH_ACTIVE) && !acc_q.is_read;
    assign busy_o      = (phase_q != PH_IDLE);
    assign done_o      = (phase_q == PH_DONE);

endmodule

// File: rtl/pio_strobe_chk.sv
module pio_strobe_chk
    import pio_strobe_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic rd_strobe_o,
    input logic wr_strobe_o,
    input logic busy_o,
    input logic done_o
);

    logic             strobe, recov;
    logic [NIB_W:0]   act_run, rec_run;

    assign strobe = rd_strobe_o || wr_strobe_o;
    assign recov  = busy_o && !strobe && !done_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_run <= '0;
            rec_run <= '0;
        end else begin
            act_run <= strobe ? ((act_run == (NIB_W+1)'(SPAN_MAX)) ? act_run : act_run + 1'b1) : '0;
            rec_run <= recov  ? ((rec_run == (NIB_W+1)'(SPAN_MAX)) ? rec_run : rec_run + 1'b1) : '0;
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rd_strobe_o && wr_strobe_o)); // R6
    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        strobe |-> (busy_o && !done_o)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7
    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o); // R7
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_o); // R8
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> (busy_o && strobe)); // R8
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o); // R9
    AST_ACT_MAX: assert property (@(posedge clk) disable iff (rst)
        strobe |-> (act_run < (NIB_W+1)'(SPAN_MAX))); // R2
    AST_REC_MAX: assert property (@(posedge clk) disable iff (rst)
        recov |-> (rec_run < (NIB_W+1)'(SPAN_MAX))); // R3
    AST_REC_AFTER: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe) |-> recov); // R3

endmodule

bind pio_strobe_gen pio_strobe_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .rd_strobe_o (rd_strobe_o),
    .wr_strobe_o (wr_strobe_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/test_pio_strobe_gen.sv
`timescale 1ns/1ps
module test_pio_strobe_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0, drive_i = 1'b0, data_cls_i = 1'b1, rd_nwr_i = 1'b1;
    logic [7:0] w_d0d = 8'h21, w_d0r = 8'h53, w_d1d = 8'h7A, w_d1r = 8'h36;
    logic       rd_s, wr_s, busy, done;

    int checks = 0, errors = 0, pushed = 0, done_n = 0;
    int act_n = 0, rec_n = 0, busy_n = 0;
    bit saw_rd = 0, saw_wr = 0, done_prev = 0, stray_strobe = 0;

    typedef struct { bit rd; int act; int rec; } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    pio_strobe_gen i_pio_strobe_gen (
        .clk(clk), .rst(rst), .start_i(start_i), .drive_i(drive_i),
        .data_cls_i(data_cls_i), .rd_nwr_i(rd_nwr_i),
        .tw_d0_data_i(w_d0d), .tw_d0_reg_i(w_d0r),
        .tw_d1_data_i(w_d1d), .tw_d1_reg_i(w_d1r),
        .rd_strobe_o(rd_s), .wr_strobe_o(wr_s), .busy_o(busy), .done_o(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R4: word picked by drive and class
    function automatic logic [7:0] pick(input logic drv, input logic cls);
        if (!drv) return cls ? w_d0d : w_d0r;
        return cls ? w_d1d : w_d1r;
    endfunction

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    task automatic issue(input logic drv, input logic cls, input logic rd);
        exp_t e;
        logic [7:0] w;
        wait_idle();
        check(!rd_s && !wr_s, "R6", "strobe while idle", rd_s | wr_s, 0);
        w = pick(drv, cls);
        e.rd = rd; e.act = int'(w[3:0]) + 1; e.rec = int'(w[7:4]) + 1;
        sb_q.push_back(e);
        pushed++;
        drive_i = drv; data_cls_i = cls; rd_nwr_i = rd; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy && (rd ? rd_s : wr_s), "R8", "busy+strobe after start",
              int'(busy && (rd ? rd_s : wr_s)), 1);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_s || wr_s) begin
                act_n++;
                if (rd_s) saw_rd = 1;
                if (wr_s) saw_wr = 1;
            end else if (busy && !done) begin
                rec_n++;
            end
            if (!busy && (rd_s || wr_s)) stray_strobe = 1;
            if (busy) busy_n++;
            if (done && done_prev) check(0, "R7", "done wider than one clock", 2, 1);
            if (done) begin
                done_n++;
                if (sb_q.size() == 0) begin
                    check(0, "R9", "unexpected access completed", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(act_n == e.act, "R2", "active clocks", act_n, e.act);
                    check(rec_n == e.rec, "R3", "recovery clocks", rec_n, e.rec);
                    check(saw_rd == e.rd && saw_wr == !e.rd, "R6", "strobe direction",
                          int'({saw_rd, saw_wr}), e.rd ? 2 : 1);
                    check(busy_n == e.act + e.rec + 1, "R8", "busy clocks",
                          busy_n, e.act + e.rec + 1);
                end
                act_n = 0; rec_n = 0; busy_n = 0; saw_rd = 0; saw_wr = 0;
            end
            done_prev = done;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!rd_s && !wr_s && !busy && !done, "R1", "outputs in reset",
              int'({rd_s, wr_s, busy, done}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!rd_s && !wr_s && !busy && !done, "R1", "outputs after reset",
              int'({rd_s, wr_s, busy, done}), 0);

        // R4: all four word selections, both directions
        issue(1'b0, 1'b1, 1'b1);
        issue(1'b0, 1'b0, 1'b0);
        issue(1'b1, 1'b1, 1'b1);
        issue(1'b1, 1'b0, 1'b0);

        // R2/R3 extremes
        wait_idle();
        w_d0d = 8'h00;
        issue(1'b0, 1'b1, 1'b0);
        wait_idle();
        w_d1r = 8'hFF;
        issue(1'b1, 1'b0, 1'b1);
        wait_idle();
        w_d0r = 8'hF0;
        issue(1'b0, 1'b0, 1'b1);
        wait_idle();
        w_d1d = 8'h0F;
        issue(1'b1, 1'b1, 1'b0);

        // R5: words change mid-access
        wait_idle();
        w_d0d = 8'h42;
        issue(1'b0, 1'b1, 1'b1);
        w_d0d = 8'hEE; w_d0r = 8'hEE; w_d1d = 8'hEE; w_d1r = 8'hEE;
        wait_idle();
        w_d0d = 8'h21; w_d0r = 8'h53; w_d1d = 8'h7A; w_d1r = 8'h36;

        // R9: start while busy is ignored
        issue(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        drive_i = 1'b1; data_cls_i = 1'b1; rd_nwr_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);
        check(!busy, "R9", "no second access after ignored start", int'(busy), 0);
        check(done_n == pushed && sb_q.size() == 0, "R7", "completions vs requests",
              done_n, pushed);
        check(!stray_strobe, "R6", "strobe outside busy", int'(stray_strobe), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule